// File: doc/BRIEF.md
# Preemptive Rotating Bus Arbiter

This block decides which requester drives a shared system bus. Four classes of requester compete for it: a group of DMA channels, a single DRAM refresh agent, a group of external bus masters and the host CPU. Each requester has its own request input and gets its own grant, preempt and forced-reset outputs. A requester asks for the bus by raising its request. It keeps the bus while the request stays high and gives the bus back by dropping the request.

Grants follow a two-level rotation. The outer level steps through four slots in a fixed loop: DMA, shared master/CPU, refresh, shared master/CPU. Slots with nobody waiting are skipped. The shared slot alternates between the CPU and the next bus master in round-robin order. DMA channels also take turns among themselves. Under load, DMA gets every fourth grant and does not wait behind a fixed-priority master.

When some other device wants the bus, the owner is asked to yield. An owner that ignores the request for a set number of clocks has its grant removed and gets a one-cycle reset. When nobody wants the bus, the CPU is parked on it.

Top module: `bus_arbiter_top`

States of the controller:
- `ST_GAP`: an idle cycle with no grant, in which the next owner is chosen.
- `ST_PARK`: the CPU holds a default grant.
- `ST_OWN`: a requester owns the bus.
- `ST_PREEMPT`: the owner is being asked to yield, and the timeout runs.
- `ST_KILL`: a one-cycle reset pulse goes to an owner that ran out of time.

Transitions:
- GAP→OWN when some request is pending.
- GAP→PARK when no request is pending.
- PARK→OWN when the CPU raises its request.
- PARK→GAP when only other requesters are waiting.
- OWN→GAP when the owner drops its request.
- OWN→PREEMPT when any other request is high.
- PREEMPT→GAP when the owner releases.
- PREEMPT→KILL when the timeout expires.
- KILL→GAP always.

## Requirements
- R1: While `rst_n` is low, no grant, preempt or kill output is high. On leaving reset, the outer rotation starts at the DMA slot, the shared slot offers the CPU first, and both round-robin groups start at index 0.
- R2: At most one grant output is high in any cycle.
- R3: The outer rotation visits slots in the order DMA, shared, refresh, shared and then repeats. Slots with no pending request are skipped. After a grant, the search resumes at the slot after the one that was used.
- R4: The shared slot gives the CPU the turn when its alternation flag points to it and the CPU is requesting. Otherwise it goes to the next requesting master after the last master served. Granting the CPU hands the next shared turn to the masters, and granting a master hands it back to the CPU. DMA channels rotate in the same round-robin way.
- R5: An owner releases the bus by dropping its request. Between the grants of two different owners there is at least one cycle with no grant.
- R6: While the owner's request is high and another request is pending, the owner's preempt output is high. Preempt is never high without that requester's grant, and it stays high until the owner releases or is killed.
- R7: If the owner still requests after its preempt output has been high for `PREEMPT_TIMEOUT` consecutive cycles, its kill output pulses for exactly one cycle with its grant low. The bus then goes to the next requester, and the killed device is not considered in the first selection after the kill.
- R8: With no requests pending, the CPU grant is high. A CPU that raises its request while parked keeps the grant with no idle cycle and no new grant edge.
- R9: Counted in grants to other requesters between a request rising and its own grant, a DMA channel waits at most 4·`NUM_DMA`, the refresh agent at most 4, the CPU at most 6 and a master at most 4·`NUM_MST`+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_req | input | NUM_DMA | Request per DMA channel |
| dma_gnt | output | NUM_DMA | Grant per DMA channel |
| dma_preempt | output | NUM_DMA | Yield request per DMA channel |
| dma_kill | output | NUM_DMA | Forced reset per DMA channel |
| refr_req | input | 1 | Refresh agent request |
| refr_gnt | output | 1 | Refresh agent grant |
| refr_preempt | output | 1 | Refresh agent yield request |
| refr_kill | output | 1 | Refresh agent forced reset |
| mst_req | input | NUM_MST | Request per bus master |
| mst_gnt | output | NUM_MST | Grant per bus master |
| mst_preempt | output | NUM_MST | Yield request per bus master |
| mst_kill | output | NUM_MST | Forced reset per bus master |
| cpu_req | input | 1 | CPU request |
| cpu_gnt | output | 1 | CPU grant (also the parked default) |
| cpu_preempt | output | 1 | CPU yield request |
| cpu_kill | output | 1 | CPU forced reset |

## Verification
The bench targets four corner cases.

First, all classes request together, with the CPU one cycle late so it is not already parked. This fixes the exact grant order. A wrong slot pointer or a missing shared-slot toggle would serve two masters back to back or serve refresh before the CPU.

Second, a master that never releases must see exactly `PREEMPT_TIMEOUT` cycles of preempt before a single kill cycle. An off-by-one timer, or a kill that leaves the grant high, shows up at once.

Third, a CPU that requests while parked must keep its grant without a gap. A design that always passes through the idle state would drop it.

Fourth, under saturating load every wait is measured against the rotation bound. Starving a class, or handing over with no idle cycle, breaks that bound or the gap check.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [2:0] {
        ST_GAP,
        ST_PARK,
        ST_OWN,
        ST_PREEMPT,
        ST_KILL
    } arb_state_t;

    typedef enum logic [1:0] {
        K_DMA,
        K_REF,
        K_MST,
        K_CPU
    } arb_kind_t;

    // Outer rotation slot codes; the odd codes are the shared master/CPU slot.
    localparam logic [1:0] SLOT_DMA = 2'd0;
    localparam logic [1:0] SLOT_REF = 2'd2;

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int W  = 2,
    parameter int PW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic          found,
    output logic [PW-1:0] idx
);

    // First requester at or after ptr, wrapping around.
    always_comb begin
        int j;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < W; k++) begin
            j = (int'(ptr) + k) % W;
            if (!found && req[j]) begin
                found = 1'b1;
                idx   = PW'(j);
            end
        end
    end

endmodule

// File: rtl/arb_next_pick.sv
module arb_next_pick import arb_pkg::*; #(
    parameter int NUM_DMA = 2,
    parameter int NUM_MST = 2,
    parameter int NREQ    = NUM_DMA + NUM_MST + 2,
    parameter int IW      = $clog2(NREQ),
    parameter int DPW     = (NUM_DMA > 1) ? $clog2(NUM_DMA) : 1,
    parameter int MPW     = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
    input  logic [NREQ-1:0] req,
    input  logic [1:0]      slot,
    input  logic            cpu_turn,
    input  logic [DPW-1:0]  dma_ptr,
    input  logic [MPW-1:0]  mst_ptr,
    output logic            found,
    output logic [IW-1:0]   idx,
    output logic [1:0]      pick_slot,
    output arb_kind_t       kind,
    output logic [DPW-1:0]  dma_sel,
    output logic [MPW-1:0]  mst_sel
);

    localparam int REF_IDX  = NUM_DMA;
    localparam int MST_BASE = NUM_DMA + 1;
    localparam int CPU_IDX  = NREQ - 1;

    logic dma_any, mst_any;

    arb_rr_pick #(.W(NUM_DMA), .PW(DPW)) u_dma_rr (
        .req   (req[NUM_DMA-1:0]),
        .ptr   (dma_ptr),
        .found (dma_any),
        .idx   (dma_sel)
    );

    arb_rr_pick #(.W(NUM_MST), .PW(MPW)) u_mst_rr (
        .req   (req[MST_BASE +: NUM_MST]),
        .ptr   (mst_ptr),
        .found (mst_any),
        .idx   (mst_sel)
    );

    // Walk the four outer slots from the current one; first usable slot wins.
    always_comb begin
        logic [1:0] s;
        found     = 1'b0;
        idx       = '0;
        pick_slot = slot;
        kind      = K_CPU;
        for (int k = 0; k < 4; k++) begin
            s = slot + 2'(k);
            if (!found) begin
                if (s == SLOT_DMA) begin
                    if (dma_any) begin
                        found = 1'b1; kind = K_DMA; pick_slot = s;
                        idx   = IW'(dma_sel);
                    end
                end else if (s == SLOT_REF) begin
                    if (req[REF_IDX]) begin
                        found = 1'b1; kind = K_REF; pick_slot = s;
                        idx   = IW'(REF_IDX);
                    end
                end else begin
                    if (req[CPU_IDX] && (cpu_turn || !mst_any)) begin
                        found = 1'b1; kind = K_CPU; pick_slot = s;
                        idx   = IW'(CPU_IDX);
                    end else if (mst_any) begin
                        found = 1'b1; kind = K_MST; pick_slot = s;
                        idx   = IW'(MST_BASE) + IW'(mst_sel);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/arb_timeout.sv
module arb_timeout #(
    parameter int LIMIT = 64,
    parameter int CW    = $clog2(LIMIT) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    logic [CW-1:0] cnt_q;

    assign expire = run && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (!expire) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT - 1));

endmodule

// File: rtl/bus_arbiter_top.sv
module bus_arbiter_top import arb_pkg::*; #(
    parameter int NUM_DMA         = 2,
    parameter int NUM_MST         = 2,
    parameter int PREEMPT_TIMEOUT = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DMA-1:0] dma_req,
    output logic [NUM_DMA-1:0] dma_gnt,
    output logic [NUM_DMA-1:0] dma_preempt,
    output logic [NUM_DMA-1:0] dma_kill,
    input  logic               refr_req,
    output logic               refr_gnt,
    output logic               refr_preempt,
    output logic               refr_kill,
    input  logic [NUM_MST-1:0] mst_req,
    output logic [NUM_MST-1:0] mst_gnt,
    output logic [NUM_MST-1:0] mst_preempt,
    output logic [NUM_MST-1:0] mst_kill,
    input  logic               cpu_req,
    output logic               cpu_gnt,
    output logic               cpu_preempt,
    output logic               cpu_kill
);

    localparam int NREQ     = NUM_DMA + NUM_MST + 2;
    localparam int IW       = $clog2(NREQ);
    localparam int DPW      = (NUM_DMA > 1) ? $clog2(NUM_DMA) : 1;
    localparam int MPW      = (NUM_MST > 1) ? $clog2(NUM_MST) : 1;
    localparam int REF_IDX  = NUM_DMA;
    localparam int MST_BASE = NUM_DMA + 1;
    localparam int CPU_IDX  = NREQ - 1;

    logic [NREQ-1:0] req_v, req_eff, owner_oh, others;
    logic [NREQ-1:0] gnt_v, pre_v, kill_v;

    arb_state_t      state_q, state_d;
    logic [IW-1:0]   owner_q, owner_d;
    logic [1:0]      slot_q;
    logic            cpu_turn_q;
    logic [DPW-1:0]  dma_ptr_q;
    logic [MPW-1:0]  mst_ptr_q;
    logic            killed_q;

    logic            pick_found;
    logic [IW-1:0]   pick_idx;
    logic [1:0]      pick_slot;
    arb_kind_t       pick_kind;
    logic [DPW-1:0]  dma_sel;
    logic [MPW-1:0]  mst_sel;
    logic            expire;

    // Flat requester order: DMA channels, refresh, masters, CPU on top.
    assign req_v    = {cpu_req, mst_req, refr_req, dma_req};
    assign owner_oh = NREQ'(1) << owner_q;
    assign others   = req_v & ~owner_oh;
    // Right after a kill the victim is left out of the next selection.
    assign req_eff  = req_v & ~((state_q == ST_GAP && killed_q) ? owner_oh : '0);

    arb_next_pick #(
        .NUM_DMA (NUM_DMA),
        .NUM_MST (NUM_MST),
        .NREQ    (NREQ),
        .IW      (IW),
        .DPW     (DPW),
        .MPW     (MPW)
    ) u_pick (
        .req       (req_eff),
        .slot      (slot_q),
        .cpu_turn  (cpu_turn_q),
        .dma_ptr   (dma_ptr_q),
        .mst_ptr   (mst_ptr_q),
        .found     (pick_found),
        .idx       (pick_idx),
        .pick_slot (pick_slot),
        .kind      (pick_kind),
        .dma_sel   (dma_sel),
        .mst_sel   (mst_sel)
    );

    arb_timeout #(.LIMIT(PREEMPT_TIMEOUT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_PREEMPT),
        .expire (expire)
    );

    // Next state and owner.
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        unique case (state_q)
            ST_GAP: begin
                if (pick_found) begin
                    state_d = ST_OWN;
                    owner_d = pick_idx;
                end else begin
                    state_d = ST_PARK;
                    owner_d = IW'(CPU_IDX);
                end
            end
            ST_PARK: begin
                owner_d = IW'(CPU_IDX);
                if (cpu_req)          state_d = ST_OWN;
                else if (|req_v)      state_d = ST_GAP;
            end
            ST_OWN: begin
                if (!req_v[owner_q])  state_d = ST_GAP;
                else if (|others)     state_d = ST_PREEMPT;
            end
            ST_PREEMPT: begin
                if (!req_v[owner_q])  state_d = ST_GAP;
                else if (expire)      state_d = ST_KILL;
            end
            ST_KILL:                  state_d = ST_GAP;
            default:                  state_d = ST_GAP;
        endcase
    end

    // State register and rotation pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_GAP;
            owner_q    <= IW'(CPU_IDX);
            slot_q     <= SLOT_DMA;
            cpu_turn_q <= 1'b1;
            dma_ptr_q  <= '0;
            mst_ptr_q  <= '0;
            killed_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            owner_q  <= owner_d;
            killed_q <= (state_q == ST_KILL);
            if (state_q == ST_GAP && pick_found) begin
                slot_q <= pick_slot + 2'd1;
                unique case (pick_kind)
                    K_DMA: dma_ptr_q <= (int'(dma_sel) == NUM_DMA - 1) ? '0 : dma_sel + 1'b1;
                    K_MST: begin
                        mst_ptr_q  <= (int'(mst_sel) == NUM_MST - 1) ? '0 : mst_sel + 1'b1;
                        cpu_turn_q <= 1'b1;
                    end
                    K_CPU: cpu_turn_q <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    // Outputs decoded from the state register.
    always_comb begin
        gnt_v  = '0;
        pre_v  = '0;
        kill_v = '0;
        unique case (state_q)
            ST_PARK:    gnt_v[CPU_IDX] = 1'b1;
            ST_OWN:     gnt_v = owner_oh;
            ST_PREEMPT: begin
                gnt_v = owner_oh;
                pre_v = owner_oh;
            end
            ST_KILL:    kill_v = owner_oh;
            default: ;
        endcase
    end

    assign dma_gnt      = gnt_v[NUM_DMA-1:0];
    assign dma_preempt  = pre_v[NUM_DMA-1:0];
    assign dma_kill     = kill_v[NUM_DMA-1:0];
    assign refr_gnt     = gnt_v[REF_IDX];
    assign refr_preempt = pre_v[REF_IDX];
    assign refr_kill    = kill_v[REF_IDX];
    assign mst_gnt      = gnt_v[MST_BASE +: NUM_MST];
    assign mst_preempt  = pre_v[MST_BASE +: NUM_MST];
    assign mst_kill     = kill_v[MST_BASE +: NUM_MST];
    assign cpu_gnt      = gnt_v[CPU_IDX];
    assign cpu_preempt  = pre_v[CPU_IDX];
    assign cpu_kill     = kill_v[CPU_IDX];

    assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_v));

    assert_pick_requested_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && pick_found) |-> req_v[pick_idx]);

    assert_idle_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_v) |=> (gnt_v == '0 || gnt_v == $past(gnt_v)));

    assert_preempt_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_v & ~gnt_v) == '0);

    assert_preempt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pre_v & req_v) != '0 && !expire) |=> pre_v == $past(pre_v));

    assert_kill_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|kill_v) |=> (kill_v == '0));

    assert_kill_nogrant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_v & gnt_v) == '0);

    assert_park_cpu_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && req_v == '0) |=> gnt_v[CPU_IDX]);

endmodule

// File: tb/bus_arbiter_top_tb_top.sv
module bus_arbiter_top_tb_top;

    localparam int ND = 2;
    localparam int NM = 2;
    localparam int TO = 64;
    localparam int N  = ND + NM + 2;
    localparam int L_D0 = 0, L_D1 = 1, L_REF = 2, L_M0 = 3, L_M1 = 4, L_CPU = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n;
    logic [N-1:0] req;
    logic [N-1:0] gnt, pre, kil;
    logic [ND-1:0] dg, dp, dk;
    logic [NM-1:0] mg, mp, mk;
    logic rg, rp, rk, cg, cp, ck;

    assign gnt = {cg, mg, rg, dg};
    assign pre = {cp, mp, rp, dp};
    assign kil = {ck, mk, rk, dk};

    bus_arbiter_top #(.NUM_DMA(ND), .NUM_MST(NM), .PREEMPT_TIMEOUT(TO)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .dma_req(req[1:0]), .dma_gnt(dg), .dma_preempt(dp), .dma_kill(dk),
        .refr_req(req[2]), .refr_gnt(rg), .refr_preempt(rp), .refr_kill(rk),
        .mst_req(req[4:3]), .mst_gnt(mg), .mst_preempt(mp), .mst_kill(mk),
        .cpu_req(req[5]), .cpu_gnt(cg), .cpu_preempt(cp), .cpu_kill(ck)
    );

    int checks = 0;
    int errors = 0;
    int q[$];
    bit qcheck = 1'b0;

    // Requester model state.
    int pend[N], hold[N], predrop[N], held[N], precnt[N];
    bit stuck[N];

    // Monitor state.
    int grise = 0, snap[N], pre_run[N], kills[N];
    bit waiting[N];
    logic [N-1:0] pg = '0, preq = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int bound(input int i);
        if (i < ND)     return 4 * ND;
        if (i == L_REF) return 4;
        if (i == L_CPU) return 6;
        return 4 * NM + 2;
    endfunction

    // Requester model: raise, hold, release on count, on preempt, or on kill.
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                req[i] = 1'b0;
            end else if (req[i]) begin
                if (kil[i]) begin
                    req[i] = 1'b0;
                    stuck[i] = 1'b0;
                end else if (gnt[i]) begin
                    held[i]++;
                    if (pre[i]) precnt[i]++;
                    if (!stuck[i] && (held[i] >= hold[i] ||
                        (predrop[i] > 0 && precnt[i] >= predrop[i])))
                        req[i] = 1'b0;
                end
            end else if (pend[i] > 0) begin
                req[i] = 1'b1;
                pend[i]--;
                held[i] = 0;
                precnt[i] = 0;
            end
        end
    end

    // Monitor / scoreboard.
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            pg = '0; preq = '0;
            for (int i = 0; i < N; i++) begin
                waiting[i] = 1'b0;
                pre_run[i] = 0;
            end
        end else begin
            if (!$onehot0(gnt)) chk(1'b0, "R2", "grants high", $countones(gnt), 1);
            if (|pg && |gnt && gnt != pg) chk(1'b0, "R5", "handover without idle", int'(gnt), 0);
            if ((pre & ~gnt) != '0) chk(1'b0, "R6", "preempt without grant", int'(pre), 0);
            for (int i = 0; i < N; i++) begin
                if (kil[i]) begin
                    chk(pre_run[i] == TO, "R7", "preempt cycles before kill", pre_run[i], TO);
                    chk(!gnt[i], "R7", "grant during kill", int'(gnt[i]), 0);
                    kills[i]++;
                end
                pre_run[i] = pre[i] ? pre_run[i] + 1 : 0;
                if (gnt[i] && !pg[i] && req[i]) begin
                    if (qcheck) begin
                        if (q.size() == 0) begin
                            chk(1'b0, "R3", "unexpected grant lane", i, -1);
                        end else begin
                            int e;
                            e = q.pop_front();
                            chk(e == i, "R3", "grant order lane", i, e);
                        end
                    end
                    if (waiting[i]) begin
                        chk(grise - snap[i] <= bound(i), "R9", "grants to others while waiting",
                            grise - snap[i], bound(i));
                        waiting[i] = 1'b0;
                    end
                    grise++;
                end
                if (req[i] && !preq[i]) begin
                    if (gnt[i]) waiting[i] = 1'b0;
                    else begin
                        waiting[i] = 1'b1;
                        snap[i] = grise;
                    end
                end
            end
            pg = gnt;
            preq = req;
        end
    end

    // Watchdog.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic ask(input int i, input int n, input int h, input int pd, input bit st);
        hold[i] = h; predrop[i] = pd; stuck[i] = st; pend[i] = n;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        qcheck = 1'b0;
        q.delete();
        for (int i = 0; i < N; i++) begin
            pend[i] = 0; stuck[i] = 1'b0; predrop[i] = 0; hold[i] = 1; kills[i] = 0;
        end
        tick(4);
        chk(gnt == '0 && pre == '0 && kil == '0, "R1", "outputs in reset", int'(gnt | pre | kil), 0);
        rst_n = 1'b1;
        tick(3);
        chk(gnt == 6'b100000, "R8", "parked grant after reset", int'(gnt), 32);
    endtask

    task automatic wait_idle();
        int guard;
        bool_loop: for (guard = 0; guard < 5000; guard++) begin
            bit busy;
            busy = (req != '0);
            for (int i = 0; i < N; i++) if (pend[i] > 0) busy = 1'b1;
            if (!busy && gnt == 6'b100000) break;
            tick(1);
        end
        chk(guard < 5000, "R5", "bus returned to park", guard, 0);
        if (qcheck) chk(q.size() == 0, "R3", "expected grants left", q.size(), 0);
    endtask

    task automatic wait_gnt(input int i);
        int guard;
        for (guard = 0; guard < 1000; guard++) begin
            if (gnt[i]) break;
            tick(1);
        end
        chk(guard < 1000, "R3", "grant reached lane", i, i);
    endtask

    initial begin
        req = '0;
        rst_n = 1'b0;

        // R3 / R4: everyone once, CPU one cycle late so it is not parked.
        do_reset();
        qcheck = 1'b1;
        q.push_back(L_D0); q.push_back(L_CPU); q.push_back(L_REF);
        q.push_back(L_M0); q.push_back(L_D1); q.push_back(L_M1);
        for (int i = 0; i < L_CPU; i++) ask(i, 1, 3, 0, 1'b0);
        tick(1);
        ask(L_CPU, 1, 3, 0, 1'b0);
        wait_idle();

        // R4: shared slot alternation, CPU then masters in order.
        do_reset();
        qcheck = 1'b1;
        q.push_back(L_CPU); q.push_back(L_M0); q.push_back(L_M1);
        ask(L_M0, 1, 2, 0, 1'b0);
        ask(L_M1, 1, 2, 0, 1'b0);
        tick(1);
        ask(L_CPU, 1, 2, 0, 1'b0);
        wait_idle();

        // R6: owner yields a few cycles after preempt, no kill.
        do_reset();
        qcheck = 1'b1;
        q.push_back(L_D0); q.push_back(L_M0);
        ask(L_D0, 1, 1000, 4, 1'b0);
        wait_gnt(L_D0);
        ask(L_M0, 1, 2, 0, 1'b0);
        tick(4);
        chk(pre[L_D0] == 1'b1, "R6", "preempt on busy owner", int'(pre[L_D0]), 1);
        wait_idle();
        chk(kills[L_D0] == 0, "R6", "kills of yielding owner", kills[L_D0], 0);

        // R7: stuck master gets killed after the timeout.
        do_reset();
        qcheck = 1'b1;
        q.push_back(L_M0); q.push_back(L_D0);
        ask(L_M0, 1, 0, 0, 1'b1);
        wait_gnt(L_M0);
        ask(L_D0, 1, 2, 0, 1'b0);
        wait_idle();
        chk(kills[L_M0] == 1, "R7", "kill pulses on stuck master", kills[L_M0], 1);

        // R8: CPU requesting while parked keeps the grant, no new edge.
        do_reset();
        begin
            int g0;
            g0 = grise;
            ask(L_CPU, 1, 6, 0, 1'b0);
            for (int k = 0; k < 5; k++) begin
                tick(1);
                chk(gnt[L_CPU] == 1'b1, "R8", "parked CPU grant kept", int'(gnt[L_CPU]), 1);
            end
            wait_idle();
            chk(grise == g0, "R8", "grant edges for parked CPU", grise - g0, 0);
        end

        // R9: saturating load on every lane, latency bounds checked by monitor.
        do_reset();
        for (int i = 0; i < N; i++) ask(i, 15, 2, 0, 1'b0);
        wait_idle();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule